// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address stream for one burst access into a bank of 2^COL_W columns (256 by default). A load strobe captures a start column, a burst length code, an ordering choice and an auto-precharge request. From the following cycle the block presents one column per enabled clock, with a valid flag and a flag that marks the final beat.

A burst runs to its programmed length, is cut short by a stop strobe, or is replaced by a new load. In full-page mode it walks every column in linear order, wrapping, until it is stopped or replaced. A low clock enable freezes every register, so the column and all flags hold. When a burst that asked for auto-precharge ends by completion or by stop, the block raises a precharge-start indication for downstream bank control.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, col_last and pre_start are 0 and col_addr is 0.
- R2: A load sampled with clk_en high makes col_valid 1 on the next cycle with col_addr equal to the loaded start column, whatever the order or length.
- R3: The length code selects the beat count: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and the reserved codes 4, 5 and 6 give 1. col_last is 1 exactly on the final beat of a fixed-length burst, and col_valid drops on the next enabled cycle.
- R4: Linear order (acc_interleave = 0), burst length L: beat k shows the start column's bits above log2(L) unchanged and low bits equal to (start + k) mod L.
- R5: Interleaved order (acc_interleave = 1), burst length L: beat k shows the start column's bits above log2(L) unchanged and low bits equal to the start's low bits XOR k.
- R6: Full page (code 7) always runs linear, ignoring acc_interleave, gives (start + k) mod 2^COL_W, wraps past the top column, and never raises col_last.
- R7: A stop sampled with clk_en high and no load during a burst makes col_valid 0 on the next cycle; a stop with no burst running has no effect.
- R8: A load during a running burst abandons it and the new start column appears on the next cycle; a load and a stop in the same cycle act as a load.
- R9: While clk_en is sampled low, col_addr, col_valid, col_last and pre_start keep their values, and load and stop are ignored.
- R10: pre_start is 1 for the enabled cycle after a burst that was loaded with acc_auto_pre = 1 ends by its final beat or by a stop; it stays 0 when the burst is abandoned by a new load, and it is never 1 while col_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes all state |
| acc_load | input | 1 | Start a new burst from the captured configuration |
| acc_start_col | input | COL_W | First column of the burst |
| acc_len_code | input | 3 | Burst length code |
| acc_interleave | input | 1 | 1 selects interleaved order, 0 linear |
| acc_auto_pre | input | 1 | Request a self-timed precharge when the burst ends |
| acc_stop | input | 1 | End the running burst early |
| col_addr | output | COL_W | Current column |
| col_valid | output | 1 | col_addr is a beat of the running burst |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |
| pre_start | output | 1 | Begin the self-timed precharge |

## Verification
The assertions check on every cycle that a load restarts at the loaded column, that stop and the final beat each end the burst on the next enabled cycle, that a low clock enable freezes all state, that the column bits above the burst window never move inside a burst, and that the precharge indication never overlaps a valid beat. The exact address order for each length in linear and interleaved mode, the full-page wrap past the top column, the mapping of the reserved length codes, and whether the precharge indication is raised or withheld after each way a burst can end are shown only by the bench's scenarios, which compare every output against a reference model on every cycle.

// File: rtl/sqx_pkg.sv
// Package: shared length codes and the decode of a length code into a
// beat window. Assumes the column width is at least 3 bits so that the
// longest fixed burst (8 beats) fits inside one row.
package sqx_pkg;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    // Number of low address bits that move inside a fixed burst.
    function automatic int unsigned window_bits(logic [2:0] code);
        case (code)
            LEN_2:   return 1;
            LEN_4:   return 2;
            LEN_8:   return 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sqx_len_decode.sv
// Module: sqx_len_decode
// Turns a burst length code into a window mask (ones over the address bits
// that move during the burst) and a full-page flag. Reserved codes fall
// back to a single beat. Purely combinational.
module sqx_len_decode
    import sqx_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    output logic [COL_W-1:0] win_mask,
    output logic             full_page
);

    // Build one mask bit per column bit from the window width.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        always_comb begin
            if (len_code == LEN_PAGE) begin
                win_mask[i] = 1'b1;
            end else begin
                win_mask[i] = (i < int'(window_bits(len_code)));
            end
        end
    end

    // Flag the page-length code.
    always_comb full_page = (len_code == LEN_PAGE);

endmodule

// File: rtl/sqx_addr_gen.sv
// Module: sqx_addr_gen
// Forms the column of beat k from the captured start column. Bits outside
// the window mask copy the start column; bits inside take either the sum
// start + k (linear) or start XOR k (interleaved). Assumes beat < window
// size for fixed bursts, and that interleave is already cleared for full
// page by the caller. Purely combinational.
module sqx_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] win_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_sum;

    // Linear candidate: plain add; carries out of the window are discarded
    // by the per-bit select below, which gives the wrap inside the block.
    always_comb lin_sum = start_col + beat;

    // Per-bit select between fixed, linear and interleaved sources.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!win_mask[i]) begin
                col[i] = start_col[i];
            end else if (interleave) begin
                col[i] = start_col[i] ^ beat[i];
            end else begin
                col[i] = lin_sum[i];
            end
        end
    end

endmodule

// File: rtl/sqx_beat_ctrl.sv
// Module: sqx_beat_ctrl
// Holds the burst state: captured configuration, beat counter, valid flag
// and the precharge-start pulse. Every register updates only when clk_en
// is high, which gives the freeze behaviour. Priority on an enabled edge:
// load, then end of burst (stop or final beat), then advance.
// Assumes cfg_* inputs are the decoded values of the current load request.
module sqx_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             acc_load,
    input  logic             acc_stop,
    input  logic [COL_W-1:0] cfg_start,
    input  logic [COL_W-1:0] cfg_mask,
    input  logic             cfg_full,
    input  logic             cfg_ilv,
    input  logic             cfg_auto_pre,
    output logic [COL_W-1:0] start_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q,
    output logic             valid_q,
    output logic             last,
    output logic             pre_q
);

    logic full_q;
    logic ap_q;
    logic burst_end;

    // Final beat of a fixed-length burst: counter has reached the window top.
    always_comb last = valid_q && !full_q && (beat_q == mask_q);

    // The burst finishes on this edge by stop or by its final beat.
    always_comb burst_end = valid_q && (acc_stop || last);

    // Capture configuration on load; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            ilv_q   <= 1'b0;
            ap_q    <= 1'b0;
        end else if (clk_en && acc_load) begin
            start_q <= cfg_start;
            mask_q  <= cfg_mask;
            full_q  <= cfg_full;
            ilv_q   <= cfg_ilv && !cfg_full;
            ap_q    <= cfg_auto_pre;
        end
    end

    // Beat counter and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= '0;
            valid_q <= 1'b0;
        end else if (clk_en) begin
            if (acc_load) begin
                beat_q  <= '0;
                valid_q <= 1'b1;
            end else if (burst_end) begin
                valid_q <= 1'b0;
            end else if (valid_q) begin
                beat_q  <= beat_q + 1'b1;
            end
        end
    end

    // Precharge-start pulse after a burst that ends without preemption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
        end else if (clk_en) begin
            pre_q <= !acc_load && burst_end && ap_q;
        end
    end

    // R8: an enabled load always restarts at beat zero with valid set.
    a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && acc_load |=> valid_q && (beat_q == '0));

    // R7: an enabled stop without load ends a running burst.
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !acc_load && valid_q && acc_stop |=> !valid_q);

    // R3: the final beat is followed by an idle cycle unless reloaded.
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !acc_load && last |=> !valid_q);

    // R9: a low enable holds every piece of burst state.
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(beat_q) && $stable(valid_q) && $stable(start_q)
                    && $stable(mask_q) && $stable(pre_q));

    // R10: the precharge pulse never overlaps a valid beat.
    a_r10_pre_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q |-> !valid_q);

    // R6: a full-page burst never reports a final beat.
    a_r6_page_open: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && full_q |-> !last);

endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Column address sequencer for one burst into a bank of 2^COL_W columns.
// Decodes the length code of a load request, keeps burst state in the
// control block and forms the visible column from that state. All outputs
// come from registers or from logic fed only by registers.
// Assumes COL_W >= 3.
module burst_col_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             acc_load,
    input  logic [COL_W-1:0] acc_start_col,
    input  logic [2:0]       acc_len_code,
    input  logic             acc_interleave,
    input  logic             acc_auto_pre,
    input  logic             acc_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             pre_start
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;

    sqx_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (acc_len_code),
        .win_mask  (dec_mask),
        .full_page (dec_full)
    );

    sqx_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .acc_load     (acc_load),
        .acc_stop     (acc_stop),
        .cfg_start    (acc_start_col),
        .cfg_mask     (dec_mask),
        .cfg_full     (dec_full),
        .cfg_ilv      (acc_interleave),
        .cfg_auto_pre (acc_auto_pre),
        .start_q      (start_q),
        .beat_q       (beat_q),
        .mask_q       (mask_q),
        .ilv_q        (ilv_q),
        .valid_q      (col_valid),
        .last         (col_last),
        .pre_q        (pre_start)
    );

    sqx_addr_gen #(.COL_W(COL_W)) u_addr (
        .start_col  (start_q),
        .beat       (beat_q),
        .win_mask   (mask_q),
        .interleave (ilv_q),
        .col        (col_addr)
    );

    // R2: the first beat after a load shows the loaded start column.
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && acc_load |=> col_valid && (col_addr == $past(acc_start_col)));

    // R4: column bits above the burst window hold while a burst advances.
    a_r4_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && col_valid && !col_last && !acc_load && !acc_stop
        |=> col_valid && ((col_addr & ~mask_q) == ($past(col_addr) & ~mask_q)));

    // R3: the last flag only accompanies a valid beat.
    a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

endmodule

// File: tb/tb_burst_col_seq.sv
// Bench for burst_col_seq: directed corner cases followed by seeded random
// traffic, every cycle compared against a reference model kept in the bench.
module tb_burst_col_seq;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b0;
    logic             acc_load = 1'b0;
    logic [COL_W-1:0] acc_start_col = '0;
    logic [2:0]       acc_len_code = '0;
    logic             acc_interleave = 1'b0;
    logic             acc_auto_pre = 1'b0;
    logic             acc_stop = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;
    logic             pre_start;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state.
    bit       m_valid = 0;
    int       m_k     = 0;
    bit [7:0] m_start = 0;
    bit [2:0] m_code  = 0;
    bit       m_ilv   = 0;
    bit       m_ap    = 0;
    bit       m_pre   = 0;

    burst_col_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .acc_load(acc_load),
        .acc_start_col(acc_start_col), .acc_len_code(acc_len_code),
        .acc_interleave(acc_interleave), .acc_auto_pre(acc_auto_pre),
        .acc_stop(acc_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .pre_start(pre_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int burst_len(bit [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic bit [7:0] exp_col(bit [7:0] s, bit [2:0] c, bit il, int k);
        bit [7:0] m;
        bit [7:0] kk;
        kk = 8'(k);
        if (c == 3'd7) return 8'(s + kk);
        m = 8'(burst_len(c) - 1);
        if (il) return (s & ~m) | ((s ^ kk) & m);
        return (s & ~m) | (8'(s + kk) & m);
    endfunction

    function automatic bit m_last();
        return m_valid && (m_code != 3'd7) && (m_k == burst_len(m_code) - 1);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model; tag the col check by mode.
    task automatic compare(string vtag);
        string ctag;
        check(vtag, int'(col_valid), int'(m_valid), "col_valid");
        check("R3", int'(col_last), int'(m_last()), "col_last");
        check("R10", int'(pre_start), int'(m_pre), "pre_start");
        if (m_valid) begin
            ctag = (m_code == 3'd7) ? "R6" : (m_ilv ? "R5" : "R4");
            check(ctag, int'(col_addr), int'(exp_col(m_start, m_code, m_ilv, m_k)), "col_addr");
        end
    endtask

    // Drive one cycle of inputs, advance the model, sample at the negedge.
    task automatic cyc(bit ce, bit ld, bit st, bit [7:0] sc, bit [2:0] lc,
                       bit il, bit ap, string vtag);
        bit lst;
        clk_en = ce; acc_load = ld; acc_stop = st; acc_start_col = sc;
        acc_len_code = lc; acc_interleave = il; acc_auto_pre = ap;
        @(posedge clk);
        lst = m_last();
        if (ce) begin
            if (ld) begin
                m_valid = 1; m_k = 0; m_start = sc; m_code = lc;
                m_ilv = il && (lc != 3'd7); m_ap = ap; m_pre = 0;
            end else if (m_valid && (st || lst)) begin
                m_valid = 0; m_pre = m_ap;
            end else if (m_valid) begin
                m_k = (m_k + 1) % 256; m_pre = 0;
            end else begin
                m_pre = 0;
            end
        end
        @(negedge clk);
        compare(vtag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, 3'd0, 0, 0, "R2");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(col_valid), 0, "col_valid");
        check("R1", int'(col_last), 0, "col_last");
        check("R1", int'(pre_start), 0, "pre_start");
        check("R1", int'(col_addr), 0, "col_addr");
        rst_n = 1'b1;
        idle(2);

        // R4: linear length 4 from 0x36 gives 36 37 34 35, with auto-precharge.
        cyc(1, 1, 0, 8'h36, 3'd2, 0, 1, "R2");
        check("R4", int'(col_addr), 8'h36, "beat0");
        idle(1); check("R4", int'(col_addr), 8'h37, "beat1");
        idle(1); check("R4", int'(col_addr), 8'h34, "beat2");
        idle(1); check("R4", int'(col_addr), 8'h35, "beat3");
        check("R3", int'(col_last), 1, "last on beat 4");
        idle(1); check("R10", int'(pre_start), 1, "pre after completion");
        idle(1); check("R10", int'(pre_start), 0, "pre single pulse");

        // R5: interleaved length 8 from 0x5B: 5B 5A 59 58 5F 5E 5D 5C.
        cyc(1, 1, 0, 8'h5B, 3'd3, 1, 0, "R2");
        idle(3); check("R5", int'(col_addr), 8'h58, "beat3");
        idle(1); check("R5", int'(col_addr), 8'h5F, "beat4");
        idle(3); check("R5", int'(col_addr), 8'h5C, "beat7");
        idle(2); check("R10", int'(pre_start), 0, "no pre without request");

        // R6: full page from 0xFE, interleave ignored, wraps, stopped at 260.
        cyc(1, 1, 0, 8'hFE, 3'd7, 1, 1, "R2");
        idle(2); check("R6", int'(col_addr), 8'h00, "wrap to 0");
        idle(257); check("R6", int'(col_addr), 8'h01, "second wrap");
        check("R6", int'(col_last), 0, "never last");
        cyc(1, 0, 1, 8'h00, 3'd0, 0, 0, "R7");
        check("R7", int'(col_valid), 0, "stop ends page burst");
        check("R10", int'(pre_start), 1, "pre after stop");

        // R7: stop while idle has no effect.
        cyc(1, 0, 1, 8'h00, 3'd0, 0, 0, "R7");
        check("R7", int'(col_valid), 0, "stop idle");

        // R9: freeze mid-burst; load and stop ignored while enable low.
        cyc(1, 1, 0, 8'h10, 3'd3, 0, 1, "R2");
        idle(2);
        cyc(0, 1, 0, 8'hAA, 3'd1, 1, 0, "R9");
        cyc(0, 0, 1, 8'h00, 3'd0, 0, 0, "R9");
        check("R9", int'(col_addr), 8'h12, "frozen column");
        check("R9", int'(col_valid), 1, "frozen valid");
        idle(1); check("R9", int'(col_addr), 8'h13, "resumes");

        // R8: preempt, no precharge on abandon; load beats stop.
        cyc(1, 1, 1, 8'hC4, 3'd1, 0, 0, "R8");
        check("R8", int'(col_addr), 8'hC4, "new start");
        check("R10", int'(pre_start), 0, "no pre on preempt");
        idle(1); check("R3", int'(col_last), 1, "len 2 last");
        // R3: reserved code 5 acts as one beat.
        cyc(1, 1, 0, 8'h77, 3'd5, 0, 0, "R3");
        check("R3", int'(col_last), 1, "reserved single beat");
        idle(2);

        // Random traffic with a fixed seed.
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            bit ce, ld, st, il, ap;
            bit [2:0] lc;
            ce = ($urandom % 100) < 85;
            ld = ($urandom % 8) == 0;
            st = ($urandom % 16) == 0;
            il = $urandom % 2;
            ap = $urandom % 2;
            lc = 3'($urandom % 8);
            if (($urandom % 4) == 0) lc = 3'd7;
            cyc(ce, ld, st, 8'($urandom), lc, il, ap, ce ? (ld ? "R8" : "R7") : "R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule